// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a load/store unit and a memory bus that only carries naturally aligned transfers. It accepts one request at a time, with a byte address, a size of 1, 2, 4 or 8 bytes, a read/write flag, write data and a flag saying that the target region only takes 32-bit transfers. It then runs the request on the bus as one or more aligned operations.

Misaligned loads are served by reading whole aligned units and shifting the wanted bytes out of the pair. Misaligned stores are broken into single-byte writes. An 8-byte transfer to a 32-bit-only region is carried as two 4-byte transfers. When a bus operation reports an error, the sequence ends at once and the error is returned with the completion pulse. Bus data is right-justified: a transfer of N bytes uses bits [8N-1:0] of the data buses, and bytes are numbered little-endian.

Top module: `unaligned_splitter`

## Requirements
- R1: A request whose address has zero in every bit below its size (size code 0/1/2/3 = 1/2/4/8 bytes) is carried as exactly one bus operation with the same address and size code, unless R6 applies.
- R2: A misaligned 4- or 8-byte load reads the aligned unit of that size holding the address, then the next one. The result is the two units read as one little-endian value, shifted right by 8 times the byte offset, keeping the low 32 or 64 bits.
- R3: A misaligned 2-byte load reads the byte at the address, then the byte at the address plus 1. The first byte is the low byte of the result.
- R4: A misaligned store of N bytes makes N byte writes at the address plus 0 up to N-1, in ascending order. Write i carries byte i of the write data.
- R5: A bus error ends the request at once. The done pulse comes with the error flag set and zero load data. Byte writes already made stay in memory.
- R6: With the 32-bit-only flag set, an 8-byte transfer becomes two 4-byte transfers: the low half at the unit address, then the high half at that address plus 4. No 8-byte operation reaches the bus.
- R7: Loads of 1, 2 and 4 bytes return their value zero-extended to 64 bits.
- R8: The block reports ready only when idle, and takes a request only then. A request offered while busy is ignored. Completion is a one-cycle done pulse.
- R9: Every bus operation is naturally aligned to its own size. Address, size and data hold steady until the bus acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Idle, request will be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code: 0/1/2/3 = 1/2/4/8 bytes |
| req_narrow | input | 1 | Target region takes 32-bit transfers only |
| req_addr | input | AW | Byte address |
| req_wdata | input | 64 | Store data, right-justified |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request ended with a bus error |
| done_rdata | output | 64 | Load result, zero-extended |
| bus_req | output | 1 | Bus operation pending |
| bus_write | output | 1 | Bus operation is a write |
| bus_size | output | 2 | Bus size code, same encoding as req_size |
| bus_addr | output | AW | Aligned bus address |
| bus_wdata | output | 64 | Bus write data, right-justified |
| bus_ack | input | 1 | Bus completes the pending operation |
| bus_err | input | 1 | Operation failed, valid with bus_ack |
| bus_rdata | input | 64 | Read data, right-justified, valid with bus_ack |

## Verification
Assertions check on every cycle that each bus operation is aligned and held steady until acknowledged. They also check that no 8-byte transfer reaches a 32-bit-only region, that misaligned stores only issue byte writes, that an error is followed by an error completion, and that done is a single pulse. The merged load values, the byte order and count of split stores, the partial writes left by a fault, and the ignoring of requests while busy are shown only by the bench. It compares results and a whole reference memory against values built byte by byte from the requirements.

// File: rtl/uas_pkg.sv
package uas_pkg;
  localparam int DATA_W   = 64;
  localparam int MAX_BYTES = DATA_W / 8;
  localparam int IDX_W    = $clog2(MAX_BYTES);
  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT} seq_state_e;
endpackage

// File: rtl/uas_split.sv
// Works out the piece list of a latched request and the bus operation
// for piece idx (and half, when an 8-byte piece is carried as two words).
module uas_split
  import uas_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]        size,
  input  logic [AW-1:0]     addr,
  input  logic              write,
  input  logic              narrow,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  idx,
  input  logic              half,
  output logic [IDX_W:0]    npieces,
  output logic              mis,
  output logic              split,
  output logic [AW-1:0]     op_addr,
  output logic [1:0]        op_size,
  output logic [DATA_W-1:0] op_wdata
);
  logic [IDX_W:0]    nbytes;
  logic [IDX_W-1:0]  lowm;
  logic [AW-1:0]     base;
  logic [AW-1:0]     p_addr;
  logic [1:0]        p_size;
  logic [DATA_W-1:0] p_data;

  always_comb begin
    nbytes  = (IDX_W+1)'(1) << size;
    lowm    = IDX_W'(nbytes - (IDX_W+1)'(1));
    mis     = (addr[IDX_W-1:0] & lowm) != '0;
    base    = addr & ~AW'(lowm);
    p_addr  = addr;
    p_size  = size;
    p_data  = wdata;
    npieces = (IDX_W+1)'(1);
    if (mis) begin
      if (write) begin
        npieces = nbytes;
        p_size  = 2'd0;
        p_addr  = addr + AW'(idx);
        p_data  = (wdata >> {idx, 3'b000}) & DATA_W'(8'hFF);
      end else if (size == 2'd1) begin
        npieces = (IDX_W+1)'(2);
        p_size  = 2'd0;
        p_addr  = addr + AW'(idx);
      end else begin
        npieces = (IDX_W+1)'(2);
        p_addr  = base + (AW'(idx) << size);
      end
    end
    split    = (p_size == 2'd3) && narrow;
    op_addr  = p_addr;
    op_size  = p_size;
    op_wdata = p_data;
    if (split) begin
      op_size  = 2'd2;
      op_addr  = p_addr + (half ? AW'(4) : AW'(0));
      op_wdata = half ? {32'b0, p_data[63:32]} : {32'b0, p_data[31:0]};
    end
  end
endmodule

// File: rtl/uas_merge.sv
// Builds the load result from the one or two piece values.
module uas_merge
  import uas_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [2:0]        off,
  input  logic              mis,
  input  logic [DATA_W-1:0] p0,
  input  logic [DATA_W-1:0] p1,
  output logic [DATA_W-1:0] rdata
);
  logic [63:0]  pair32;
  logic [127:0] pair64;

  always_comb begin
    pair32 = {p1[31:0], p0[31:0]} >> {off[1:0], 3'b000};
    pair64 = {p1, p0} >> {off, 3'b000};
    rdata  = '0;
    if (!mis) begin
      case (size)
        2'd0:    rdata = {56'b0, p0[7:0]};
        2'd1:    rdata = {48'b0, p0[15:0]};
        2'd2:    rdata = {32'b0, p0[31:0]};
        default: rdata = p0;
      endcase
    end else begin
      case (size)
        2'd1:    rdata = {48'b0, p1[7:0], p0[7:0]};
        2'd2:    rdata = {32'b0, pair32[31:0]};
        default: rdata = pair64[63:0];
      endcase
    end
  end
endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import uas_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_narrow,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              done_err,
  output logic [DATA_W-1:0] done_rdata,
  output logic              bus_req,
  output logic              bus_write,
  output logic [1:0]        bus_size,
  output logic [AW-1:0]     bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata
);
  seq_state_e        state;
  logic              r_write, r_narrow, r_half;
  logic [1:0]        r_size;
  logic [AW-1:0]     r_addr;
  logic [DATA_W-1:0] r_wdata, r_p0, r_p1;
  logic [IDX_W-1:0]  r_idx;
  logic [31:0]       r_lo;

  logic [IDX_W:0]    npieces;
  logic              mis, split;
  logic [AW-1:0]     op_addr;
  logic [1:0]        op_size;
  logic [DATA_W-1:0] op_wdata;
  logic [DATA_W-1:0] piece_val, m_p0, m_p1, merged;
  logic              last_piece;

  uas_split #(.AW(AW)) i_split (
    .size(r_size), .addr(r_addr), .write(r_write), .narrow(r_narrow),
    .wdata(r_wdata), .idx(r_idx), .half(r_half), .npieces(npieces),
    .mis(mis), .split(split), .op_addr(op_addr), .op_size(op_size),
    .op_wdata(op_wdata)
  );

  always_comb begin
    piece_val  = split ? {bus_rdata[31:0], r_lo} : bus_rdata;
    m_p0       = (r_idx == '0) ? piece_val : r_p0;
    m_p1       = (r_idx != '0) ? piece_val : r_p1;
    last_piece = ({1'b0, r_idx} == npieces - (IDX_W+1)'(1));
  end

  uas_merge i_merge (
    .size(r_size), .off(r_addr[2:0]), .mis(mis),
    .p0(m_p0), .p1(m_p1), .rdata(merged)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      r_write    <= 1'b0;
      r_narrow   <= 1'b0;
      r_half     <= 1'b0;
      r_size     <= 2'd0;
      r_addr     <= '0;
      r_wdata    <= '0;
      r_p0       <= '0;
      r_p1       <= '0;
      r_idx      <= '0;
      r_lo       <= '0;
      done       <= 1'b0;
      done_err   <= 1'b0;
      done_rdata <= '0;
      bus_req    <= 1'b0;
      bus_write  <= 1'b0;
      bus_size   <= 2'd0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            r_write  <= req_write;
            r_narrow <= req_narrow;
            r_size   <= req_size;
            r_addr   <= req_addr;
            r_wdata  <= req_wdata;
            r_idx    <= '0;
            r_half   <= 1'b0;
            state    <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          bus_req   <= 1'b1;
          bus_write <= r_write;
          bus_size  <= op_size;
          bus_addr  <= op_addr;
          bus_wdata <= op_wdata;
          state     <= ST_WAIT;
        end
        default: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            if (bus_err) begin
              done       <= 1'b1;
              done_err   <= 1'b1;
              done_rdata <= '0;
              state      <= ST_IDLE;
            end else if (split && !r_half) begin
              r_lo   <= bus_rdata[31:0];
              r_half <= 1'b1;
              state  <= ST_LAUNCH;
            end else begin
              r_p0 <= m_p0;
              r_p1 <= m_p1;
              if (last_piece) begin
                done       <= 1'b1;
                done_err   <= 1'b0;
                done_rdata <= r_write ? '0 : merged;
                state      <= ST_IDLE;
              end else begin
                r_idx  <= r_idx + IDX_W'(1);
                r_half <= 1'b0;
                state  <= ST_LAUNCH;
              end
            end
          end
        end
      endcase
    end
  end

  // R9: natural alignment of every bus operation
  a_r9_bus_aligned: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> ((bus_addr[2:0] & ((3'd1 << bus_size) - 3'd1)) == 3'd0));
  // R9: operation held until acknowledged
  a_r9_bus_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                               $stable(bus_size) && $stable(bus_wdata)));
  // R6: no 8-byte transfer toward a 32-bit-only region
  a_r6_no_wide: assert property (@(posedge clk) disable iff (rst)
    (bus_req && r_narrow) |-> (bus_size != 2'd3));
  // R4: misaligned stores go out as byte writes only
  a_r4_byte_writes: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_write && mis) |-> (bus_size == 2'd0));
  // R5: a bus error ends the request with the error flag
  a_r5_err_done: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && bus_err) |=> (done && done_err && done_rdata == '0));
  // R8: done is a single-cycle pulse, seen while idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);
endmodule

// File: tb/test_unaligned_splitter.sv
module test_unaligned_splitter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_narrow = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, done, done_err;
  logic [63:0] done_rdata;
  logic        bus_req, bus_write;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr;
  logic [63:0] bus_wdata;
  logic        bus_ack = 1'b0, bus_err = 1'b0;
  logic [63:0] bus_rdata = '0;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] mem_m [256];
  logic [7:0] ref_m [256];
  int op_cnt = 0, lat = 0;
  logic [31:0] first_addr;
  logic [1:0]  first_size;
  logic        cur_narrow = 1'b0;

  unaligned_splitter #(.AW(32)) i_unaligned_splitter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_narrow(req_narrow),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
    .done_err(done_err), .done_rdata(done_rdata), .bus_req(bus_req),
    .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit is_fault(input logic [31:0] a);
    return a[7:4] == 4'hF;
  endfunction

  // bus memory model
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0; bus_err = 1'b0; lat = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0; bus_err = 1'b0; lat = $urandom % 3;
    end else if (bus_req) begin
      if (lat != 0) lat--;
      else begin
        int nb;
        nb = 1 << bus_size;
        chk((bus_addr & 32'(nb - 1)) == 0, "R9 alignment", 64'(bus_addr), 64'(bus_addr & ~32'(nb - 1)));
        if (cur_narrow) chk(bus_size != 2'd3, "R6 wide op", 64'(bus_size), 64'd2);
        if (op_cnt == 0) begin first_addr = bus_addr; first_size = bus_size; end
        op_cnt++;
        bus_rdata = '0;
        bus_err = is_fault(bus_addr);
        if (!bus_err) begin
          for (int i = 0; i < nb; i++) begin
            if (bus_write) mem_m[8'(bus_addr + 32'(i))] = bus_wdata[8*i +: 8];
            else bus_rdata[8*i +: 8] = mem_m[8'(bus_addr + 32'(i))];
          end
        end
        bus_ack = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic string tag_of(input bit w, input logic [1:0] sz,
                                   input logic [31:0] a, input bit nar);
    int nb;
    nb = 1 << sz;
    if ((a & 32'(nb - 1)) == 0) return (sz == 2'd3 && nar) ? "R6" : "R1";
    if (w) return "R4";
    if (sz == 2'd1) return "R3";
    return "R2";
  endfunction

  task automatic run(input bit w, input logic [1:0] sz, input logic [31:0] a,
                     input bit nar, input logic [63:0] wd);
    int nb, exp_ops, t;
    bit misal, exp_err, got_err;
    logic [63:0] exp_val, got;
    string tg;
    nb = 1 << sz;
    misal = (a & 32'(nb - 1)) != 0;
    tg = tag_of(w, sz, a, nar);
    exp_err = 1'b0;
    exp_val = '0;
    for (int i = 0; i < nb; i++) begin
      if (is_fault(a + 32'(i))) exp_err = 1'b1;
      if (!w) exp_val[8*i +: 8] = ref_m[8'(a + 32'(i))];
    end
    if (exp_err) exp_val = '0;
    if (!misal) exp_ops = (sz == 2'd3 && nar) ? 2 : 1;
    else if (w) exp_ops = nb;
    else exp_ops = (sz == 2'd3 && nar) ? 4 : 2;
    // reference memory update
    if (w) begin
      for (int i = 0; i < nb; i++) begin
        if (is_fault(a + 32'(i))) break;
        if (!misal && exp_err) break;
        ref_m[8'(a + 32'(i))] = wd[8*i +: 8];
      end
    end
    @(negedge clk);
    chk(req_ready, "R8 ready when idle", 64'(req_ready), 64'd1);
    op_cnt = 0;
    cur_narrow = nar;
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a;
    req_narrow = nar; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    got_err = done_err;
    got = done_rdata;
    chk(done, "R8 done pulse", 64'(done), 64'd1);
    if (exp_err) chk(got_err == 1'b1 && got == '0, "R5 error result", {got[62:0], got_err}, 64'd1);
    else begin
      chk(got_err == 1'b0, {tg, " no error"}, 64'(got_err), 64'd0);
      if (!w) chk(got == exp_val, (sz != 2'd3) ? {tg, "/R7 load data"} : {tg, " load data"}, got, exp_val);
      chk(op_cnt == exp_ops, {tg, " op count"}, 64'(op_cnt), 64'(exp_ops));
      if (!misal && !(sz == 2'd3 && nar))
        chk(first_addr == a && first_size == sz, "R1 passthrough op",
            {30'b0, first_size, first_addr}, {30'b0, sz, a});
      if (sz == 2'd3 && nar && !misal)
        chk(first_addr == a && first_size == 2'd2, "R6 low half first",
            {30'b0, first_size, first_addr}, {30'b0, 2'd2, a});
    end
    @(negedge clk);
    chk(!done, "R8 single pulse", 64'(done), 64'd0);
    if (w) begin
      bit same;
      same = 1'b1;
      for (int i = 0; i < 256; i++) if (mem_m[i] !== ref_m[i]) same = 1'b0;
      chk(same, exp_err ? "R5 partial writes kept" : "R4 memory image", 64'(same), 64'd1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem_m[i] = 8'($urandom);
      ref_m[i] = mem_m[i];
    end
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && !bus_req, "R8 reset state",
        {61'b0, req_ready, done, bus_req}, 64'd4);

    // directed corner cases
    run(1'b0, 2'd2, 32'h40, 1'b0, '0);               // R1 aligned word
    run(1'b0, 2'd0, 32'h43, 1'b0, '0);               // R7 byte load
    for (int o = 1; o < 4; o++) run(1'b0, 2'd2, 32'h50 + 32'(o), 1'b0, '0); // R2
    run(1'b0, 2'd3, 32'h65, 1'b0, '0);               // R2 8-byte
    run(1'b0, 2'd1, 32'h27, 1'b0, '0);               // R3
    run(1'b0, 2'd3, 32'h78, 1'b1, '0);               // R6 load
    run(1'b1, 2'd3, 32'h80, 1'b1, 64'h1122334455667788); // R6 store
    run(1'b0, 2'd3, 32'h83, 1'b1, '0);               // R2+R6
    run(1'b1, 2'd2, 32'h31, 1'b0, 64'hA1B2C3D4);     // R4
    run(1'b1, 2'd3, 32'hEB, 1'b0, 64'h0102030405060708); // R5 partial store
    run(1'b0, 2'd2, 32'hEE, 1'b0, '0);               // R5 load fault

    // R8: request offered while busy is ignored
    begin
      logic [7:0] keep;
      keep = mem_m[8'h10];
      @(negedge clk);
      cur_narrow = 1'b0; op_cnt = 0;
      req_valid = 1'b1; req_write = 1'b1; req_size = 2'd3; req_addr = 32'h91;
      req_narrow = 1'b0; req_wdata = 64'hFFEEDDCCBBAA9988;
      for (int i = 0; i < 8; i++) ref_m[8'h91 + i] = req_wdata[8*i +: 8];
      @(negedge clk);
      req_addr = 32'h10; req_size = 2'd0; req_wdata = 64'h0;
      keep = ~keep;
      req_wdata[7:0] = keep;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(mem_m[8'h10] == ~keep && op_cnt == 8, "R8 busy request ignored",
          {op_cnt[7:0], mem_m[8'h10]}, {8'd8, ~keep});
    end

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [1:0] sz;
      logic [31:0] a;
      sz = 2'($urandom);
      a  = 32'($urandom % 256);
      if (a + (32'd1 << sz) > 32'd256) a = 32'h10;
      run(1'($urandom), sz, a, 1'($urandom), {$urandom, $urandom});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule